// File: doc/BRIEF.md
# Bandwidth Slot Schedule Builder

This block computes the time-slot schedule of a slot-based memory arbiter. The schedule has 64 entries, and each entry names one of 14 clients. Two memory regions are handled. Each region keeps its own per-client reservation counts, its own active flags and its own schedule. A command names a region, a client and a slot count. The block first checks whether that region has room for the request. If it does, it stores the request and rebuilds the whole table of that region.

A rebuild has two phases. In the first, every client with a nonzero reservation gets entries spaced at a fixed stride. When an entry is already taken, the client moves forward one entry and tries again. In the second, each entry still free is handed round-robin to the clients flagged active. Every entry of the finished table leaves through a write port as region, index and client id, and a single done pulse then reports the result. Converting bandwidth to slots, and the arbitration datapath that reads the table, are outside this block.

Top module: `ssb_slot_schedule_builder`

## Requirements
- R1: After reset, `busy`, `wr_en`, `done`, `accepted` and `rejected` are low, and both regions have no reservations and no active clients.
- R2: A command is rejected when its client id is 14 or more, or when its slot count is nonzero and the region's reserved total, plus the number of its active clients, plus the new count, plus one, is greater than 64. A rejected command changes no stored state and starts no writes. `done` and `rejected` pulse together one cycle after the command is taken.
- R3: An accepted command raises `busy` in the next cycle. It then produces exactly 64 writes, with `wr_index` running 0 to 63 on consecutive cycles. `done` and `accepted` pulse in the cycle after the last write, and `busy` falls in that same cycle.
- R4: A reserving client with count k uses the stride 64/k, rounded down. It starts at entry 0. It takes each free entry it lands on and then jumps by the stride. It steps by one over each taken entry. It stops when the position reaches 64.
- R5: Reserving clients are placed one after another in ascending client id order, so a lower id claims its entries first.
- R6: Each entry left free is filled in ascending index order by a round-robin pointer. The pointer is 0 at the start of every rebuild and carries over from one free entry to the next. It skips inactive clients, and after each grant it moves to the granted client plus one, modulo 14.
- R7: If no client in the region is active, each free entry goes to the client the pointer names, and the pointer then advances by one.
- R8: A nonzero accepted count is stored as the client's reservation and sets its active flag. A count of zero is always accepted for a valid client id. It clears the client's reservation, leaves its active flag as it was, and still triggers a rebuild.
- R9: The two regions keep separate state. `wr_region` equals the region of the command being served, and a rebuild of one region leaves the other region's later schedule unchanged.
- R10: A command presented while `busy` is high is ignored. It gives no response, and it leaves no trace in any later schedule.
- R11: `wr_client` is always below 14 when `wr_en` is high. The empty marker 15 never leaves the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe; taken when `busy` is low |
| cmd_region | input | 1 | Region the command applies to |
| cmd_client | input | 4 | Client id |
| cmd_slots | input | 7 | Requested slot count; 0 clears the reservation |
| busy | output | 1 | High while a rebuild is running |
| wr_en | output | 1 | Schedule write strobe |
| wr_region | output | 1 | Region of the write |
| wr_index | output | 6 | Schedule entry index |
| wr_client | output | 4 | Client id stored in the entry |
| done | output | 1 | One-cycle response pulse |
| accepted | output | 1 | Qualifies `done`: request admitted |
| rejected | output | 1 | Qualifies `done`: request refused |

## Verification
An internal error shows up at the ports of the rebuild that follows it. A wrong reservation count or active flag changes the entries written in that rebuild. A wrong round-robin pointer shifts every free-entry grant after the first bad one. A mistake in the admission total only becomes visible at a later accept or reject decision, where it flips the `done` qualifier. The bench keeps its own model of both regions' state, with expected tables worked out arithmetically. It compares every one of the 64 writes of every rebuild, so a fault shows within the same rebuild, or at the latest within the next command to that region.

// File: rtl/ssb_pkg.sv
// Package: shared state encoding for the slot schedule builder.
// Assumes: nothing beyond the enum being used by the table builder FSM.
package ssb_pkg;

    typedef enum logic [2:0] {
        BLD_IDLE,   // waiting for an admitted request
        BLD_SEL,    // choosing the next reserving client
        BLD_STEP,   // walking one reserving client along the table
        BLD_FILL,   // round-robin fill and output of every entry
        BLD_FIN     // one-cycle completion pulse
    } bld_state_e;

endpackage

// File: rtl/ssb_client_state.sv
// Module: per-region, per-client reservation counts and active flags.
// Computes the admission decision for the presented command, and serves
// one region's state to the table builder.
// Assumes: upd_en is only raised for a command that passed admission.
module ssb_client_state #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 14,
    parameter int NUM_REGIONS = 2,
    parameter int CW          = 4,
    parameter int NW          = 7,
    parameter int RW          = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd_en,
    input  logic [RW-1:0]          upd_region,
    input  logic [CW-1:0]          upd_client,
    input  logic [NW-1:0]          upd_slots,
    output logic                   adm_ok,
    input  logic [RW-1:0]          rd_region,
    output logic [NW-1:0]          rd_req [NUM_CLIENTS],
    output logic [NUM_CLIENTS-1:0] rd_act
);

    localparam int SW = $clog2((NUM_CLIENTS + 2) * (NUM_SLOTS + 1)) + 1;

    logic [NW-1:0] req_q [NUM_REGIONS][NUM_CLIENTS];
    logic          act_q [NUM_REGIONS][NUM_CLIENTS];
    logic [SW-1:0] total;

    // Sum of reserved slots and active clients in the addressed region.
    always_comb begin
        total = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (upd_region == RW'(r)) begin
                for (int c = 0; c < NUM_CLIENTS; c++) begin
                    total = total + SW'(req_q[r][c]) + SW'(act_q[r][c]);
                end
            end
        end
    end

    // Admission: valid client id, and a zero count or room for the request.
    always_comb begin
        adm_ok = (upd_client < CW'(NUM_CLIENTS)) &&
                 ((upd_slots == '0) ||
                  (total + SW'(upd_slots) + SW'(1) <= SW'(NUM_SLOTS)));
    end

    // Read port: the selected region's counts and flags for the builder.
    always_comb begin
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            rd_req[c] = '0;
            rd_act[c] = 1'b0;
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (rd_region == RW'(r)) begin
                    rd_req[c] = req_q[r][c];
                    rd_act[c] = act_q[r][c];
                end
            end
        end
    end

    // Storage update: record the count, flag the client on a nonzero count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                for (int c = 0; c < NUM_CLIENTS; c++) begin
                    req_q[r][c] <= '0;
                    act_q[r][c] <= 1'b0;
                end
            end
        end else if (upd_en) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                for (int c = 0; c < NUM_CLIENTS; c++) begin
                    if (upd_region == RW'(r) && upd_client == CW'(c)) begin
                        req_q[r][c] <= upd_slots;
                        if (upd_slots != '0) begin
                            act_q[r][c] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R2: admission keeps every region's load within the table size.
    assert_total_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        total <= SW'(NUM_SLOTS));

endmodule

// File: rtl/ssb_rr_pick.sv
// Module: round-robin search for the next active client from a pointer.
// Falls back to the pointer itself when no client is active.
// Assumes: ptr < NUM_CLIENTS.
module ssb_rr_pick #(
    parameter int NUM_CLIENTS = 14,
    parameter int CW          = 4
) (
    input  logic [CW-1:0]          ptr,
    input  logic [NUM_CLIENTS-1:0] act,
    output logic [CW-1:0]          pick,
    output logic [CW-1:0]          next_ptr
);

    logic found;

    // Scan from the pointer with wrap-around; first active client wins.
    always_comb begin
        pick  = ptr;
        found = 1'b0;
        for (int i = 0; i < NUM_CLIENTS; i++) begin
            int idx;
            idx = int'(ptr) + i;
            if (idx >= NUM_CLIENTS) begin
                idx = idx - NUM_CLIENTS;
            end
            if (!found && act[idx]) begin
                pick  = CW'(idx);
                found = 1'b1;
            end
        end
    end

    // Pointer after a grant: one past the granted client, modulo the count.
    always_comb begin
        next_ptr = (pick == CW'(NUM_CLIENTS - 1)) ? '0 : pick + CW'(1);
    end

endmodule

// File: rtl/ssb_table_builder.sv
// Module: rebuilds one region's schedule and streams it out.
// Places reserving clients at strided positions, then fills the free
// entries round-robin, writing one entry per cycle.
// Assumes: start is only raised while busy is low; the store's read
// region follows wr_region, which holds the region being built.
module ssb_table_builder
    import ssb_pkg::*;
#(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 14,
    parameter int CW          = 4,
    parameter int NW          = 7,
    parameter int RW          = 1,
    parameter int IW          = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [RW-1:0]          start_region,
    input  logic [NW-1:0]          rd_req [NUM_CLIENTS],
    input  logic [NUM_CLIENTS-1:0] rd_act,
    output logic                   busy,
    output logic                   wr_en,
    output logic [RW-1:0]          wr_region,
    output logic [IW-1:0]          wr_index,
    output logic [CW-1:0]          wr_client,
    output logic                   done
);

    localparam int PW  = $clog2(2 * NUM_SLOTS);
    localparam int CLW = $clog2(NUM_CLIENTS + 1);

    bld_state_e     state_q;
    logic [RW-1:0]  reg_q;
    logic [CLW-1:0] cli_q;
    logic [PW-1:0]  pos_q;
    logic [PW-1:0]  stride_q;
    logic [IW-1:0]  fill_q;
    logic [CW-1:0]  ptr_q;
    logic [NUM_SLOTS-1:0] occ_q;
    logic [CW-1:0]  tab_q [NUM_SLOTS];
    logic           wr_en_q;
    logic [IW-1:0]  wr_idx_q;
    logic [CW-1:0]  wr_cli_q;
    logic           done_q;

    logic [NW-1:0]  cur_req;
    logic [PW-1:0]  cur_stride;
    logic [IW-1:0]  pos_idx;
    logic [CW-1:0]  rr_pick;
    logic [CW-1:0]  rr_next;

    // Count of the client under placement.
    always_comb begin
        cur_req = '0;
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            if (cli_q == CLW'(c)) begin
                cur_req = rd_req[c];
            end
        end
    end

    // Stride of the client under placement; guarded against a zero count.
    always_comb begin
        cur_stride = (cur_req == '0) ? PW'(1) : PW'(NUM_SLOTS / int'(cur_req));
        pos_idx    = pos_q[IW-1:0];
    end

    ssb_rr_pick #(
        .NUM_CLIENTS(NUM_CLIENTS),
        .CW         (CW)
    ) u_rr (
        .ptr     (ptr_q),
        .act     (rd_act),
        .pick    (rr_pick),
        .next_ptr(rr_next)
    );

    // Rebuild sequencer: clear, place reservations, fill and emit entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= BLD_IDLE;
            reg_q    <= '0;
            cli_q    <= '0;
            pos_q    <= '0;
            stride_q <= '0;
            fill_q   <= '0;
            ptr_q    <= '0;
            occ_q    <= '0;
            wr_en_q  <= 1'b0;
            wr_idx_q <= '0;
            wr_cli_q <= '0;
            done_q   <= 1'b0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                tab_q[s] <= '0;
            end
        end else begin
            wr_en_q <= 1'b0;
            done_q  <= 1'b0;
            case (state_q)
                BLD_IDLE: begin
                    if (start) begin
                        reg_q   <= start_region;
                        occ_q   <= '0;
                        cli_q   <= '0;
                        ptr_q   <= '0;
                        state_q <= BLD_SEL;
                    end
                end
                BLD_SEL: begin
                    if (cli_q == CLW'(NUM_CLIENTS)) begin
                        fill_q  <= '0;
                        state_q <= BLD_FILL;
                    end else if (cur_req != '0) begin
                        stride_q <= cur_stride;
                        pos_q    <= '0;
                        state_q  <= BLD_STEP;
                    end else begin
                        cli_q <= cli_q + CLW'(1);
                    end
                end
                BLD_STEP: begin
                    if (pos_q >= PW'(NUM_SLOTS)) begin
                        cli_q   <= cli_q + CLW'(1);
                        state_q <= BLD_SEL;
                    end else if (occ_q[pos_idx]) begin
                        pos_q <= pos_q + PW'(1);
                    end else begin
                        occ_q[pos_idx] <= 1'b1;
                        tab_q[pos_idx] <= cli_q[CW-1:0];
                        pos_q          <= pos_q + stride_q;
                    end
                end
                BLD_FILL: begin
                    wr_en_q  <= 1'b1;
                    wr_idx_q <= fill_q;
                    if (occ_q[fill_q]) begin
                        wr_cli_q <= tab_q[fill_q];
                    end else begin
                        wr_cli_q <= rr_pick;
                        ptr_q    <= rr_next;
                    end
                    if (fill_q == IW'(NUM_SLOTS - 1)) begin
                        state_q <= BLD_FIN;
                    end else begin
                        fill_q <= fill_q + IW'(1);
                    end
                end
                BLD_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= BLD_IDLE;
                end
                default: state_q <= BLD_IDLE;
            endcase
        end
    end

    // Output drive from the registered write and response stage.
    always_comb begin
        busy      = (state_q != BLD_IDLE);
        wr_en     = wr_en_q;
        wr_region = reg_q;
        wr_index  = wr_idx_q;
        wr_client = wr_cli_q;
        done      = done_q;
    end

    // R3: writes only appear while a rebuild is in progress.
    assert_write_in_build_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R3: back-to-back writes step the index by one.
    assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_index == $past(wr_index) + IW'(1)));

    // R3: completion directly follows the write of the last entry.
    assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && $past(wr_index) == IW'(NUM_SLOTS - 1)));

    // R11: the empty marker never leaves the block.
    assert_client_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_client < CW'(NUM_CLIENTS)));

endmodule

// File: rtl/ssb_slot_schedule_builder.sv
// Module: top of the slot schedule builder. Takes commands while idle,
// runs admission, updates the client state and starts the rebuild, and
// merges the accept and reject responses.
// Assumes: NUM_REGIONS >= 2 and NUM_CLIENTS + 1 fits in the client width.
module ssb_slot_schedule_builder #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 14,
    parameter int NUM_REGIONS = 2,
    parameter int CW          = $clog2(NUM_CLIENTS + 2),
    parameter int NW          = $clog2(NUM_SLOTS + 1),
    parameter int RW          = $clog2(NUM_REGIONS),
    parameter int IW          = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [RW-1:0] cmd_region,
    input  logic [CW-1:0] cmd_client,
    input  logic [NW-1:0] cmd_slots,
    output logic          busy,
    output logic          wr_en,
    output logic [RW-1:0] wr_region,
    output logic [IW-1:0] wr_index,
    output logic [CW-1:0] wr_client,
    output logic          done,
    output logic          accepted,
    output logic          rejected
);

    logic                   fire;
    logic                   adm_ok;
    logic                   upd_en;
    logic                   rej_q;
    logic                   bld_done;
    logic                   bld_busy;
    logic [RW-1:0]          bld_region;
    logic [NW-1:0]          rd_req [NUM_CLIENTS];
    logic [NUM_CLIENTS-1:0] rd_act;

    // Command take: only while no rebuild runs.
    always_comb begin
        fire   = cmd_valid && !bld_busy;
        upd_en = fire && adm_ok;
    end

    ssb_client_state #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_CLIENTS(NUM_CLIENTS),
        .NUM_REGIONS(NUM_REGIONS),
        .CW         (CW),
        .NW         (NW),
        .RW         (RW)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .upd_region(cmd_region),
        .upd_client(cmd_client),
        .upd_slots (cmd_slots),
        .adm_ok    (adm_ok),
        .rd_region (bld_region),
        .rd_req    (rd_req),
        .rd_act    (rd_act)
    );

    ssb_table_builder #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_CLIENTS(NUM_CLIENTS),
        .CW         (CW),
        .NW         (NW),
        .RW         (RW),
        .IW         (IW)
    ) u_build (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (upd_en),
        .start_region(cmd_region),
        .rd_req      (rd_req),
        .rd_act      (rd_act),
        .busy        (bld_busy),
        .wr_en       (wr_en),
        .wr_region   (bld_region),
        .wr_index    (wr_index),
        .wr_client   (wr_client),
        .done        (bld_done)
    );

    // Reject response register: one cycle after a refused command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_q <= 1'b0;
        end else begin
            rej_q <= fire && !adm_ok;
        end
    end

    // Response merge onto the output pins.
    always_comb begin
        busy      = bld_busy;
        wr_region = bld_region;
        done      = bld_done || rej_q;
        accepted  = bld_done;
        rejected  = rej_q;
    end

    // R2: every response carries exactly one qualifier.
    assert_resp_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (accepted != rejected));

    // R2: a refusal starts no rebuild and writes nothing.
    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rejected |-> (!busy && !wr_en));

    // R10: a command offered during a rebuild draws no refusal.
    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !rejected);

endmodule

// File: tb/sim_ssb_slot_schedule_builder.sv
`timescale 1ns/1ps
module sim_ssb_slot_schedule_builder;

    localparam int NS = 64;
    localparam int NC = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [0:0] cmd_region = '0;
    logic [3:0] cmd_client = '0;
    logic [6:0] cmd_slots = '0;
    logic       busy, wr_en, done, accepted, rejected;
    logic [0:0] wr_region;
    logic [5:0] wr_index;
    logic [3:0] wr_client;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    int mreq [2][NC];
    bit mact [2][NC];
    int exp_tab [NS];
    bit exp_res [NS];
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    ssb_slot_schedule_builder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_region(cmd_region), .cmd_client(cmd_client), .cmd_slots(cmd_slots),
        .busy(busy), .wr_en(wr_en), .wr_region(wr_region), .wr_index(wr_index),
        .wr_client(wr_client), .done(done), .accepted(accepted), .rejected(rejected)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    // Expected schedule of one region from the requirement rules (R4 to R7).
    function automatic void build_expected(input int r);
        int p;
        for (int s = 0; s < NS; s++) begin
            exp_tab[s] = NC + 1;
            exp_res[s] = 1'b0;
        end
        for (int c = 0; c < NC; c++) begin
            if (mreq[r][c] != 0) begin
                int stride;
                int pos;
                stride = NS / mreq[r][c];
                pos = 0;
                while (pos < NS) begin
                    if (exp_tab[pos] != NC + 1) pos++;
                    else begin
                        exp_tab[pos] = c;
                        exp_res[pos] = 1'b1;
                        pos += stride;
                    end
                end
            end
        end
        p = 0;
        for (int s = 0; s < NS; s++) begin
            if (exp_tab[s] == NC + 1) begin
                int pick;
                pick = p;
                for (int i = 0; i < NC; i++) begin
                    if (mact[r][(p + i) % NC]) begin
                        pick = (p + i) % NC;
                        break;
                    end
                end
                exp_tab[s] = pick;
                p = (pick + 1) % NC;
            end
        end
    endfunction

    function automatic bit model_admit(input int r, input int c, input int s);
        int tot;
        if (c >= NC) return 1'b0;
        if (s == 0) return 1'b1;
        tot = 0;
        for (int k = 0; k < NC; k++) tot += mreq[r][k] + int'(mact[r][k]);
        return (tot + s + 1 <= NS);
    endfunction

    // One command; optionally a second command is offered while busy (R10).
    task automatic run_cmd(input int r, input int c, input int s,
                           input bit probe, input int pc, input int ps);
        bit ok;
        int cnt;
        int cyc;
        ok = model_admit(r, c, s);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_region = 1'(r);
        cmd_client = 4'(c);
        cmd_slots  = 7'(s);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!ok) begin
            check(done && rejected && !accepted, "R2 reject response", {done, rejected, accepted}, 3'b110);
            check(!busy && !wr_en, "R2 no rebuild on reject", {busy, wr_en}, 0);
            return;
        end
        mreq[r][c] = s;
        if (s != 0) mact[r][c] = 1'b1;
        build_expected(r);
        check(busy && !done, "R3 busy after accept", {busy, done}, 2'b10);
        cnt = 0;
        cyc = 0;
        while (!done && cyc < 4000) begin
            if (wr_en) begin
                check(int'(wr_index) == cnt, "R3 write index", wr_index, cnt);
                check(int'(wr_region) == r, "R9 write region", wr_region, r);
                check(int'(wr_client) < NC, "R11 client range", wr_client, NC - 1);
                if (cnt < NS) begin
                    if (exp_res[cnt])
                        check(int'(wr_client) == exp_tab[cnt], "R4 R5 reserved entry", wr_client, exp_tab[cnt]);
                    else
                        check(int'(wr_client) == exp_tab[cnt], "R6 R7 free entry", wr_client, exp_tab[cnt]);
                end
                cnt++;
            end
            if (rejected) check(1'b0, "R10 response while busy", rejected, 0);
            if (probe && cyc == 4) begin
                cmd_valid  = 1'b1;
                cmd_region = 1'(r);
                cmd_client = 4'(pc);
                cmd_slots  = 7'(ps);
            end
            if (probe && cyc == 5) cmd_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        if (!done) begin
            check(1'b0, "R3 rebuild watchdog", cyc, 0);
            return;
        end
        check(cnt == NS, "R3 write count", cnt, NS);
        check(accepted && !rejected && !busy && !wr_en, "R3 done response",
              {accepted, rejected, busy, wr_en}, 4'b1000);
    endtask

    // Global watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !finished) begin
                check(1'b0, "R3 global watchdog", cycles, 190000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < NC; c++) begin
                mreq[r][c] = 0;
                mact[r][c] = 1'b0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset
        check({busy, wr_en, done, accepted, rejected} == 5'b0, "R1 reset outputs",
              {busy, wr_en, done, accepted, rejected}, 0);
        // R1, R7, R8: zero request from reset, nothing active -> 0..13 cycling
        run_cmd(0, 3, 0, 1'b0, 0, 0);
        // R4: single reserver at stride 16
        run_cmd(0, 2, 4, 1'b0, 0, 0);
        // R5: higher id steps over the lower id's entries
        run_cmd(0, 5, 3, 1'b0, 0, 0);
        // R2: over capacity and out-of-range client
        run_cmd(0, 7, 60, 1'b0, 0, 0);
        run_cmd(0, 14, 1, 1'b0, 0, 0);
        run_cmd(0, 14, 0, 1'b0, 0, 0);
        // R2: exact boundary, total 7 + 2 active + 54 + 1 = 64 accepted
        run_cmd(0, 9, 54, 1'b0, 0, 0);
        run_cmd(0, 9, 55, 1'b0, 0, 0);
        run_cmd(0, 9, 0, 1'b0, 0, 0);
        // R8: clear keeps the active flag
        run_cmd(0, 2, 0, 1'b0, 0, 0);
        // R9: other region independent
        run_cmd(1, 0, 8, 1'b0, 0, 0);
        run_cmd(0, 1, 0, 1'b0, 0, 0);
        // R10: command during busy leaves no trace
        run_cmd(1, 9, 5, 1'b1, 12, 2);
        run_cmd(1, 0, 0, 1'b0, 0, 0);
        // Sweep of mixed commands against the model
        for (int n = 0; n < 150; n++) begin
            int v;
            int s;
            v = int'(rnd() % 10);
            if (v < 3) s = 0;
            else if (v < 8) s = 1 + int'(rnd() % 6);
            else s = int'(rnd() % 70);
            run_cmd(int'(rnd() % 2), int'(rnd() % 15), s, (v == 5), int'(rnd() % 14), 1);
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule